// File: doc/BRIEF.md
# Clock Source Failover Policy Controller

This block decides which of two clock sources, a primary and a backup, feeds the downstream clock selector. Each source arrives with a graded health level from an external monitor. A warning on the active source prepares a failover. A fault on the active source carries it out, provided the action gate is open. After every switch the controller waits through a hold-off period. It then watches the newly selected source for a stability interval before it treats the switch as good.

Going back to the primary is deliberately harder than leaving it. The primary must stay clean for a longer qualification interval. The return then happens on its own, or only after an operator confirmation when automatic return is disabled. Switches are counted within a time window. An attempt beyond the allowed count is refused and parks the controller in a latched oscillation state. A failed stability check, or a fault on the backup at the moment of failover, parks it in a latched fault state. Only an operator clear leaves either latched state. The glitch-free clock multiplexer itself lives outside this block.

Top module: `clk_failover_ctrl`

## Requirements
- R1: After reset the state is PRIMARY (code 0), `use_backup` is 0 and `cause` is 0.
- R2: Health levels are coded 0 = OK, 1 = WARN, 2 or 3 = FAULT. In PRIMARY, any non-OK primary level moves the state to ARMED (code 1) without switching. In ARMED, an OK primary level returns to PRIMARY, and a WARN level holds ARMED.
- R3: Only ARMED can fail over. A FAULT primary level in ARMED, with the gate open, sets `use_backup` to 1 and `cause` to 1 on the next edge and enters HOLDOFF (code 2). A FAULT seen in PRIMARY only arms the path.
- R4: If the backup level is FAULT when a failover would run, no switch happens and the state goes to FAULT_LATCHED (code 6).
- R5: The switch counter starts a window of WIN_CYC cycles at the first counted switch and clears when that window ends. An execution attempt made while the count has reached RATE_MAX does not switch and enters PINGPONG_LATCHED (code 7).
- R6: HOLDOFF lasts exactly HOLD_CYC cycles, whatever the source levels, and then moves to OBSERVE (code 3).
- R7: OBSERVE lasts STABLE_CYC cycles and then moves to ON_BACKUP (code 4) or PRIMARY, according to `use_backup`. A FAULT on the selected source during OBSERVE moves the state to FAULT_LATCHED.
- R8: In ON_BACKUP, an OK primary level moves the state to REVERT_QUAL (code 5). In REVERT_QUAL, any non-OK primary level moves it back to ON_BACKUP.
- R9: After REVERT_CYC cycles in REVERT_QUAL with the primary OK, the return runs (`use_backup` goes to 0, HOLDOFF). It carries `cause` 2 when `auto_revert` is 1. Otherwise it waits for `revert_ok` and carries `cause` 3.
- R10: FAULT_LATCHED and PINGPONG_LATCHED hold until `op_clear` is 1. The clear leaves for ON_BACKUP if `use_backup` is 1 and for PRIMARY otherwise, and it zeroes the switch count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pri_lvl | input | 2 | Primary source health level |
| bak_lvl | input | 2 | Backup source health level |
| auto_revert | input | 1 | Permit return to primary without confirmation |
| revert_ok | input | 1 | Operator confirmation for the return |
| op_clear | input | 1 | Operator clear of the latched states |
| use_backup | output | 1 | Source selection to the clock mux |
| state | output | 3 | Controller state code |
| cause | output | 2 | Reason code of the last switch |

## Verification
The bench builds the block with HOLD_CYC 4, STABLE_CYC 6, REVERT_CYC 12, RATE_MAX 2 and WIN_CYC 64. These values are small enough that the bench can check every cycle of hold-off, observation and revert qualification, state by state. Two switches fit well inside one window, so the ping-pong refusal is reachable. A 60-cycle idle period lets the window expire, which shows that a later return is allowed again.

// File: rtl/clk_failover_ctrl.sv
module clk_failover_ctrl #(
  parameter int HOLD_CYC   = 4,
  parameter int STABLE_CYC = 6,
  parameter int REVERT_CYC = 12,
  parameter int RATE_MAX   = 2,
  parameter int WIN_CYC    = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pri_lvl,
  input  logic [1:0] bak_lvl,
  input  logic       auto_revert,
  input  logic       revert_ok,
  input  logic       op_clear,
  output logic       use_backup,
  output logic [2:0] state,
  output logic [1:0] cause
);
  localparam logic [2:0] S_PRI = 3'd0, S_ARM = 3'd1, S_HOLD = 3'd2, S_OBS = 3'd3,
                         S_ONB = 3'd4, S_RQ = 3'd5, S_FL = 3'd6, S_PP = 3'd7;
  localparam int TMAX = (REVERT_CYC > STABLE_CYC) ?
                        ((REVERT_CYC > HOLD_CYC) ? REVERT_CYC : HOLD_CYC) :
                        ((STABLE_CYC > HOLD_CYC) ? STABLE_CYC : HOLD_CYC);
  localparam int TW = $clog2(TMAX + 1);
  localparam int WW = $clog2(WIN_CYC + 1);
  localparam int CW = $clog2(RATE_MAX + 1);

  logic [TW-1:0] tmr;
  logic [WW-1:0] wtmr;
  logic [CW-1:0] sw_cnt;

  wire [1:0] act_lvl   = use_backup ? bak_lvl : pri_lvl;
  wire       pri_bad   = pri_lvl[1];
  wire       bak_bad   = bak_lvl[1];
  wire       rate_full = (32'(sw_cnt) >= RATE_MAX);
  wire       wexp      = (32'(wtmr) == WIN_CYC - 1);
  wire       latched   = (state == S_FL) || (state == S_PP);
  wire       rq_done   = (32'(tmr) == REVERT_CYC - 1);
  wire       rq_go     = (state == S_RQ) && !bak_bad && (pri_lvl == 2'd0) && rq_done &&
                         (auto_revert || revert_ok);
  wire       fail_go   = (state == S_ARM) && pri_bad && !bak_bad;
  wire       fire      = (fail_go || rq_go) && !rate_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_cnt <= '0;
      wtmr   <= '0;
    end else if (latched && op_clear) begin
      sw_cnt <= '0;
      wtmr   <= '0;
    end else if (fire) begin
      if (sw_cnt == '0 || wexp) begin
        sw_cnt <= CW'(1);
        wtmr   <= '0;
      end else begin
        sw_cnt <= sw_cnt + 1'b1;
        wtmr   <= wtmr + 1'b1;
      end
    end else if (sw_cnt != '0) begin
      if (wexp) begin
        sw_cnt <= '0;
        wtmr   <= '0;
      end else begin
        wtmr <= wtmr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_PRI;
      use_backup <= 1'b0;
      cause      <= 2'd0;
      tmr        <= '0;
    end else begin
      case (state)
        S_PRI: if (pri_lvl != 2'd0) state <= S_ARM;
        S_ARM: begin
          if (pri_lvl == 2'd0) state <= S_PRI;
          else if (pri_bad) begin
            if (bak_bad) state <= S_FL;
            else if (rate_full) state <= S_PP;
            else begin
              use_backup <= 1'b1;
              cause      <= 2'd1;
              state      <= S_HOLD;
              tmr        <= '0;
            end
          end
        end
        S_HOLD: begin
          if (32'(tmr) == HOLD_CYC - 1) begin
            state <= S_OBS;
            tmr   <= '0;
          end else tmr <= tmr + 1'b1;
        end
        S_OBS: begin
          if (act_lvl[1]) state <= S_FL;
          else if (32'(tmr) == STABLE_CYC - 1) begin
            state <= use_backup ? S_ONB : S_PRI;
            tmr   <= '0;
          end else tmr <= tmr + 1'b1;
        end
        S_ONB: begin
          if (bak_bad) state <= S_FL;
          else if (pri_lvl == 2'd0) begin
            state <= S_RQ;
            tmr   <= '0;
          end
        end
        S_RQ: begin
          if (bak_bad) state <= S_FL;
          else if (pri_lvl != 2'd0) state <= S_ONB;
          else if (!rq_done) tmr <= tmr + 1'b1;
          else if (auto_revert || revert_ok) begin
            if (rate_full) state <= S_PP;
            else begin
              use_backup <= 1'b0;
              cause      <= auto_revert ? 2'd2 : 2'd3;
              state      <= S_HOLD;
              tmr        <= '0;
            end
          end
        end
        default: if (op_clear) state <= use_backup ? S_ONB : S_PRI;
      endcase
    end
  end
endmodule

module clk_failover_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bak_lvl,
  input logic       op_clear,
  input logic       use_backup,
  input logic [2:0] state,
  input logic [1:0] cause
);
  // R3
  sel_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (use_backup != $past(use_backup)) |-> (state == 3'd2));
  // R3
  fail_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(use_backup) |-> (cause == 2'd1));
  // R4
  bak_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(use_backup) |-> ($past(bak_lvl[1]) == 1'b0));
  // R10
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd6 && !op_clear) |=> (state == 3'd6));
  // R10
  pp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd7 && !op_clear) |=> (state == 3'd7));
  // R6
  hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd2 && $past(state) != 3'd2) |-> ($past(state) == 3'd1 || $past(state) == 3'd5));
endmodule

bind clk_failover_ctrl clk_failover_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bak_lvl(bak_lvl), .op_clear(op_clear),
  .use_backup(use_backup), .state(state), .cause(cause)
);

// File: tb/test_clk_failover_ctrl.sv
`timescale 1ns/100ps
module test_clk_failover_ctrl;
  localparam int H = 4, S = 6, RV = 12, RM = 2, WC = 64;
  localparam logic [2:0] PRI = 0, ARM = 1, HOLD = 2, OBS = 3, ONB = 4, RQ = 5, FL = 6, PP = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] pri_lvl = 0, bak_lvl = 0;
  logic auto_revert = 0, revert_ok = 0, op_clear = 0;
  logic use_backup;
  logic [2:0] state;
  logic [1:0] cause;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clk_failover_ctrl #(.HOLD_CYC(H), .STABLE_CYC(S), .REVERT_CYC(RV), .RATE_MAX(RM), .WIN_CYC(WC))
    i_clk_failover_ctrl (.clk(clk), .rst_n(rst_n), .pri_lvl(pri_lvl), .bak_lvl(bak_lvl),
      .auto_revert(auto_revert), .revert_ok(revert_ok), .op_clear(op_clear),
      .use_backup(use_backup), .state(state), .cause(cause));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input logic [2:0] st, input logic sel, input string tag);
    total++;
    if (state !== st || use_backup !== sel) begin
      bad++;
      $display("FAIL %s: state=%0d sel=%0d expected state=%0d sel=%0d", tag, state, use_backup, st, sel);
    end
  endtask

  task automatic chkc(input logic [1:0] c, input string tag);
    total++;
    if (cause !== c) begin
      bad++;
      $display("FAIL %s: cause=%0d expected %0d", tag, cause, c);
    end
  endtask

  task automatic hold_obs(input logic sel, input logic [2:0] endst, input string tag);
    for (int i = 1; i < H; i++) begin step(); chk(HOLD, sel, "R6"); end
    step(); chk(OBS, sel, "R6");
    for (int i = 1; i < S; i++) begin step(); chk(OBS, sel, "R7"); end
    step(); chk(endst, sel, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run hung");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(PRI, 0, "R1"); chkc(0, "R1");
    // R2 warn only arms
    pri_lvl = 1; step(); chk(ARM, 0, "R2"); step(); chk(ARM, 0, "R2");
    pri_lvl = 0; step(); chk(PRI, 0, "R2");
    // R3 fault arms then executes
    pri_lvl = 2; step(); chk(ARM, 0, "R3");
    step(); chk(HOLD, 1, "R3"); chkc(1, "R3");
    hold_obs(1, ONB, "R7");
    step(); chk(ONB, 1, "R8");
    // R8 revert qualification interrupted
    pri_lvl = 0; step(); chk(RQ, 1, "R8"); step(); chk(RQ, 1, "R8");
    pri_lvl = 1; step(); chk(ONB, 1, "R8");
    // R9 auto revert
    pri_lvl = 0; auto_revert = 1; step(); chk(RQ, 1, "R8");
    for (int i = 1; i < RV; i++) begin step(); chk(RQ, 1, "R9"); end
    step(); chk(HOLD, 0, "R9"); chkc(2, "R9");
    hold_obs(0, PRI, "R7");
    // R5 third switch inside window refused
    pri_lvl = 2; step(); chk(ARM, 0, "R5");
    step(); chk(PP, 0, "R5");
    step(); chk(PP, 0, "R10");
    op_clear = 1; pri_lvl = 0; step(); chk(PRI, 0, "R10"); op_clear = 0;
    // R4 backup faulty at execution
    pri_lvl = 2; step(); chk(ARM, 0, "R4");
    bak_lvl = 3; step(); chk(FL, 0, "R4");
    step(); chk(FL, 0, "R10");
    bak_lvl = 0; pri_lvl = 0; op_clear = 1; step(); chk(PRI, 0, "R10"); op_clear = 0;
    // R7 stability failure; R6 hold-off ignores levels
    pri_lvl = 2; step(); chk(ARM, 0, "R3");
    step(); chk(HOLD, 1, "R3");
    bak_lvl = 2;
    for (int i = 1; i < H; i++) begin step(); chk(HOLD, 1, "R6"); end
    step(); chk(OBS, 1, "R6");
    step(); chk(FL, 1, "R7");
    bak_lvl = 0; op_clear = 1; step(); chk(ONB, 1, "R10"); op_clear = 0;
    // R9 manual revert waits for confirmation
    auto_revert = 0; pri_lvl = 0; step(); chk(RQ, 1, "R8");
    for (int i = 1; i < RV; i++) begin step(); chk(RQ, 1, "R9"); end
    for (int i = 0; i < 5; i++) begin step(); chk(RQ, 1, "R9"); end
    revert_ok = 1; step(); chk(HOLD, 0, "R9"); chkc(3, "R9"); revert_ok = 0;
    hold_obs(0, PRI, "R7");
    // R5 window expiry re-enables switching
    pri_lvl = 2; step(); chk(ARM, 0, "R3");
    step(); chk(HOLD, 1, "R3");
    hold_obs(1, ONB, "R7");
    for (int i = 0; i < 60; i++) step();
    chk(ONB, 1, "R8");
    auto_revert = 1; pri_lvl = 0; step(); chk(RQ, 1, "R8");
    for (int i = 1; i < RV; i++) step();
    step(); chk(HOLD, 0, "R5"); chkc(2, "R5");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule